// File: doc/BRIEF.md
# ADC serial result frame receiver

This block sits on the host side of a serial link from a sigma-delta converter. It captures each 32-slot result frame and turns it into parallel fields in the system clock domain. The converter supplies a serial clock, a data line, an active-low frame-sync level and an active-low data-ready pulse. The four lines are asynchronous to the system clock, so each one passes through a two-flop synchronizer before any edge is detected. A frame is taken only after a data-ready pulse has armed the receiver. While frame-sync is low, the data line is sampled on each falling edge of the serial clock.

The first 31 slots of a frame are kept and the tri-stated 32nd slot is thrown away. The kept bits are split into a 24-bit two's-complement sample, which is sign-extended to the output width, a 3-bit device address and four flags. The flag that marks valid data is passed out with every result. When it is clear, the result is marked as not valid rather than withheld. A frame that closes after fewer than 31 captured slots produces no result and gives a one-cycle error pulse instead.

Results leave on a valid/ready stream that holds one result. `res_valid` stays high and every result field stays stable until a cycle in which `res_ready` is high. With `res_ready` held high, each result appears as a one-cycle strobe. A frame that completes while an earlier result is still waiting is dropped, and the waiting result is kept. The downstream side should therefore accept each result before the next frame ends.

Top module: `adc_frame_rx`

## Requirements
- R1: The data line is sampled on the falling edge of the serial clock. A value that is present only around a rising edge is never captured.
- R2: Frame slots 1 to 24 form the sample, with the MSB first. Slot 1 is the first slot after frame-sync falls.
- R3: `res_sample` is the 24-bit sample sign-extended to 32 bits, so bits 31..24 all equal bit 23.
- R4: Slots 25 to 27 form `res_addr`, with the MSB first.
- R5: Slot 28 drives `res_dvalid`, and slots 29, 30 and 31 drive `res_ovr`, `res_lpwr` and `res_filt_ok` in that order. A result whose slot 28 is 0 is still delivered, with `res_dvalid` low.
- R6: Slot 32 has no effect on any output. A frame that ends after exactly 31 slots is accepted.
- R7: A frame that is armed and closes with fewer than 31 falling edges produces no result. It pulses `frame_err` high for exactly one cycle.
- R8: A frame-sync low period that is not preceded by a rising edge of data-ready produces neither a result nor an error. The receiver is disarmed at the end of every frame.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid` and all result fields hold their values. A frame that completes in that state is dropped.
- R10: After reset, `res_valid` and `frame_err` are low and `res_sample` is zero.
- R11: With `res_ready` held high, each completed frame raises `res_valid` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the converter (asynchronous) |
| ser_data | input | 1 | Serial data line (asynchronous) |
| ser_fsync_n | input | 1 | Frame-sync level, low during a frame (asynchronous) |
| ser_drdy_n | input | 1 | Data-ready pulse, active low (asynchronous) |
| res_ready | input | 1 | Downstream accepts the held result |
| res_valid | output | 1 | A result is held on the result fields |
| res_sample | output | 32 | Sign-extended sample |
| res_addr | output | 3 | Device address field |
| res_dvalid | output | 1 | Valid-data flag of the result |
| res_ovr | output | 1 | Overrange flag |
| res_lpwr | output | 1 | Low-power flag |
| res_filt_ok | output | 1 | Filter-settled flag |
| frame_err | output | 1 | One-cycle pulse for a short frame |

## Verification
The assertions take four things for granted about the inputs. Each level of the serial clock lasts at least three system clocks. The data line is steady for two system clocks before each falling edge. Frame-sync moves only while the serial clock is idle. Successive frames are separated by many system clocks. Under those conditions the synchronized edges arrive in order and no result can land in the cycle right after another. The bench keeps within them by holding each serial clock level for four system clocks. It sets the data line two clocks before each falling edge, then inverts it three clocks later and at each rising edge. It puts idle gaps around every frame-sync change.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
  // Slot layout of one serial result frame; positions are behaviour.
  localparam int FRAME_SLOTS = 32;
  localparam int KEEP_SLOTS  = FRAME_SLOTS - 1;
  localparam int SAMPLE_W    = 24;
  localparam int ADDR_W      = 3;
  localparam int CNT_W       = $clog2(FRAME_SLOTS + 1);
  // Bit positions inside the kept word (first slot received lands at the top).
  localparam int SAMPLE_LO   = KEEP_SLOTS - SAMPLE_W;
  localparam int ADDR_HI     = SAMPLE_LO - 1;
  localparam int DVALID_POS  = ADDR_HI - ADDR_W;
  localparam int OVR_POS     = DVALID_POS - 1;
  localparam int LPWR_POS    = OVR_POS - 1;
  localparam int FOK_POS     = LPWR_POS - 1;
endpackage

// File: rtl/adc_rx_sync.sv
module adc_rx_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL[b]}};
        else        pipe <= {pipe[STAGES-2:0], d[b]};
      end
      assign q[b] = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/adc_rx_edge.sv
module adc_rx_edge #(
  parameter bit RISING  = 1'b1,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);
  logic prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end
  generate
    if (RISING) begin : g_rise
      assign pulse = lvl & ~prev;
    end else begin : g_fall
      assign pulse = ~lvl & prev;
    end
  endgenerate
endmodule

// File: rtl/adc_rx_deser.sv
module adc_rx_deser
  import adc_rx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_fall,
  input  logic                  sdata,
  input  logic                  fsync_n,
  input  logic                  fsync_rise,
  input  logic                  drdy_rise,
  output logic [KEEP_SLOTS-1:0] word,
  output logic                  done,
  output logic                  err
);
  logic [CNT_W-1:0]      cnt;
  logic [KEEP_SLOTS-1:0] sr;
  logic                  armed;
  logic                  take;

  assign take = armed && !fsync_n && sclk_fall;
  assign word = sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sr    <= '0;
      armed <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (drdy_rise) armed <= 1'b1;
      if (take) begin
        if (cnt < CNT_W'(KEEP_SLOTS)) sr <= {sr[KEEP_SLOTS-2:0], sdata};
        if (cnt < CNT_W'(FRAME_SLOTS)) cnt <= cnt + 1'b1;
      end
      if (fsync_rise) begin
        if (armed) begin
          if (cnt >= CNT_W'(KEEP_SLOTS)) done <= 1'b1;
          else                           err  <= 1'b1;
        end
        armed <= 1'b0;
        cnt   <= '0;
      end
    end
  end

  // R7: an error only follows a frame that stopped short of the kept slots
  a_r7_short_err: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(cnt) < CNT_W'(KEEP_SLOTS)));
  // R7: the error is a single-cycle pulse
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  // R8: a completed frame requires the receiver to have been armed
  a_r8_done_armed: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(armed));
  // R6: the slot counter never runs past one frame
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_SLOTS));
endmodule

// File: rtl/adc_rx_out.sv
module adc_rx_out
  import adc_rx_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [KEEP_SLOTS-1:0] word,
  input  logic                  done,
  input  logic                  ready,
  output logic                  valid,
  output logic [OUT_W-1:0]      sample,
  output logic [ADDR_W-1:0]     addr,
  output logic                  dvalid,
  output logic                  ovr,
  output logic                  lpwr,
  output logic                  filt_ok
);
  localparam int EXT_W = OUT_W - SAMPLE_W;
  logic load;
  assign load = done && (!valid || ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      sample  <= '0;
      addr    <= '0;
      dvalid  <= 1'b0;
      ovr     <= 1'b0;
      lpwr    <= 1'b0;
      filt_ok <= 1'b0;
    end else if (load) begin
      valid   <= 1'b1;
      sample  <= {{EXT_W{word[KEEP_SLOTS-1]}}, word[KEEP_SLOTS-1 -: SAMPLE_W]};
      addr    <= word[ADDR_HI -: ADDR_W];
      dvalid  <= word[DVALID_POS];
      ovr     <= word[OVR_POS];
      lpwr    <= word[LPWR_POS];
      filt_ok <= word[FOK_POS];
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R9: a held result stays put until it is accepted
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(sample) && $stable(addr) &&
                           $stable(dvalid) && $stable(ovr) && $stable(lpwr) &&
                           $stable(filt_ok)));
  // R3: the upper bits of a presented sample all copy its sign
  a_r3_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((&sample[OUT_W-1:SAMPLE_W-1]) || !(|sample[OUT_W-1:SAMPLE_W-1])));
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
  import adc_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OUT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_fsync_n,
  input  logic              ser_drdy_n,
  input  logic              res_ready,
  output logic              res_valid,
  output logic [OUT_W-1:0]  res_sample,
  output logic [ADDR_W-1:0] res_addr,
  output logic              res_dvalid,
  output logic              res_ovr,
  output logic              res_lpwr,
  output logic              res_filt_ok,
  output logic              frame_err
);
  // Synchronized bus order: {drdy_n, fsync_n, data, clk}
  localparam int         NSIG    = 4;
  localparam logic [3:0] IDLE_LV = 4'b1100;

  logic [NSIG-1:0]       raw, syn;
  logic                  sclk_fall, fsync_rise, drdy_rise;
  logic [KEEP_SLOTS-1:0] word;
  logic                  done;

  assign raw = {ser_drdy_n, ser_fsync_n, ser_data, ser_clk};

  adc_rx_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LV)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn));

  adc_rx_edge #(.RISING(1'b0), .RST_VAL(IDLE_LV[0])) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .lvl(syn[0]), .pulse(sclk_fall));
  adc_rx_edge #(.RISING(1'b1), .RST_VAL(IDLE_LV[2])) u_fsync_edge (
    .clk(clk), .rst_n(rst_n), .lvl(syn[2]), .pulse(fsync_rise));
  adc_rx_edge #(.RISING(1'b1), .RST_VAL(IDLE_LV[3])) u_drdy_edge (
    .clk(clk), .rst_n(rst_n), .lvl(syn[3]), .pulse(drdy_rise));

  adc_rx_deser u_deser (
    .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .sdata(syn[1]),
    .fsync_n(syn[2]), .fsync_rise(fsync_rise), .drdy_rise(drdy_rise),
    .word(word), .done(done), .err(frame_err));

  adc_rx_out #(.OUT_W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .word(word), .done(done), .ready(res_ready),
    .valid(res_valid), .sample(res_sample), .addr(res_addr),
    .dvalid(res_dvalid), .ovr(res_ovr), .lpwr(res_lpwr), .filt_ok(res_filt_ok));

  // R7: a short-frame error never coincides with a new result being loaded
  a_r7_err_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !$rose(res_valid));
endmodule

// File: tb/sim_adc_frame_rx.sv
module sim_adc_frame_rx;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_fsync_n = 1'b1, ser_drdy_n = 1'b1;
  logic res_ready = 1'b1;
  logic res_valid, res_dvalid, res_ovr, res_lpwr, res_filt_ok, frame_err;
  logic [31:0] res_sample;
  logic [2:0]  res_addr;

  adc_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_fsync_n(ser_fsync_n), .ser_drdy_n(ser_drdy_n), .res_ready(res_ready),
    .res_valid(res_valid), .res_sample(res_sample), .res_addr(res_addr),
    .res_dvalid(res_dvalid), .res_ovr(res_ovr), .res_lpwr(res_lpwr),
    .res_filt_ok(res_filt_ok), .frame_err(frame_err));

  int n_chk = 0, n_fail = 0, n_res = 0, n_err = 0, n_vcyc = 0;
  logic [31:0] l_sample = '0;
  logic [2:0]  l_addr = '0;
  logic [3:0]  l_flags = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (res_valid) n_vcyc++;
      if (frame_err) n_err++;
      if (res_valid && res_ready) begin
        n_res++;
        l_sample = res_sample;
        l_addr   = res_addr;
        l_flags  = {res_dvalid, res_ovr, res_lpwr, res_filt_ok};
      end
    end
  end

  // Frame word: slot 1 is bit 31, slot 32 is bit 0.
  localparam logic [31:0] VEC [6] = '{
    32'h7FFFFF5F, 32'h800000A0, 32'hFFFFFFF0,
    32'h12345631, 32'h12345630, 32'hC0FFEE8A };

  function automatic logic [31:0] x_sample(input logic [31:0] w);
    return {{8{w[31]}}, w[31:8]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w, input int nbits, input bit arm);
    if (arm) begin
      ser_drdy_n = 1'b0; wclk(8); ser_drdy_n = 1'b1; wclk(6);
    end
    ser_fsync_n = 1'b0; wclk(4);
    for (int i = 0; i < nbits; i++) begin
      ser_clk = 1'b1; ser_data = ~w[31-i]; wclk(2);
      ser_data = w[31-i]; wclk(2);
      ser_clk = 1'b0; wclk(3);
      ser_data = ~w[31-i]; wclk(1);
    end
    wclk(4); ser_fsync_n = 1'b1; wclk(12);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int n0, e0, v0;
    wclk(4);
    chk("R10 valid after reset", {31'd0, res_valid}, 32'd0);
    chk("R10 err after reset", {31'd0, frame_err}, 32'd0);
    chk("R10 sample after reset", res_sample, 32'd0);
    rst_n = 1'b1; wclk(4);

    // Vector walk: R1 R2 R3 R4 R5 R6 R11
    for (int i = 0; i < 6; i++) begin
      n0 = n_res; v0 = n_vcyc;
      send(VEC[i], 32, 1'b1);
      chk("R2 one result", n_res, n0 + 1);
      chk("R11 valid one cycle", n_vcyc, v0 + 1);
      chk("R1/R2/R3 sample", l_sample, x_sample(VEC[i]));
      chk("R4 addr", {29'd0, l_addr}, {29'd0, VEC[i][7:5]});
      chk("R5/R6 flags", {28'd0, l_flags}, {28'd0, VEC[i][4:1]});
    end

    // R6: a 31-slot frame is accepted
    n0 = n_res;
    send(32'hA5A5A5E7, 31, 1'b1);
    chk("R6 31-slot accepted", n_res, n0 + 1);
    chk("R6 31-slot sample", l_sample, x_sample(32'hA5A5A5E7));

    // R7: short frames
    n0 = n_res; e0 = n_err;
    send(32'h0F0F0F0F, 30, 1'b1);
    chk("R7 30-slot no result", n_res, n0);
    chk("R7 30-slot err once", n_err, e0 + 1);
    send(32'h0F0F0F0F, 5, 1'b1);
    chk("R7 5-slot no result", n_res, n0);
    chk("R7 5-slot err once", n_err, e0 + 2);

    // R8: frame without a data-ready pulse
    n0 = n_res; e0 = n_err;
    send(32'h11111111, 32, 1'b0);
    chk("R8 unarmed no result", n_res, n0);
    chk("R8 unarmed no err", n_err, e0);
    chk("R8 unarmed no valid", {31'd0, res_valid}, 32'd0);
    send(32'h22222222, 32, 1'b1);
    chk("R8 rearmed result", l_sample, x_sample(32'h22222222));

    // R9: back-pressure
    n0 = n_res;
    res_ready = 1'b0;
    send(32'h3456789A, 32, 1'b1);
    chk("R9 held valid", {31'd0, res_valid}, 32'd1);
    chk("R9 held sample", res_sample, x_sample(32'h3456789A));
    send(32'hFEDCBA12, 32, 1'b1);
    chk("R9 still valid", {31'd0, res_valid}, 32'd1);
    chk("R9 sample kept", res_sample, x_sample(32'h3456789A));
    chk("R9 addr kept", {29'd0, res_addr}, {29'd0, 3'b100});
    res_ready = 1'b1; wclk(1);
    chk("R9 accepted once", n_res, n0 + 1);
    chk("R9 accepted value", l_sample, x_sample(32'h3456789A));
    wclk(20);
    chk("R9 second dropped", n_res, n0 + 1);
    chk("R9 valid low after", {31'd0, res_valid}, 32'd0);

    summary();
    $finish;
  end
endmodule